// File: doc/BRIEF.md
# Multiplexed Segment LCD Display Memory Controller

This block holds the picture for a multiplexed segment LCD with up to four common (backplane) lines. A 32-entry by 4-bit data memory is filled through a small write port that is open only while chip-select is held low. The port offers four strobes. A pointer load places the 5-bit write pointer anywhere in the memory. A nibble write stores one 4-bit value and steps the pointer by one. A decoded write stores one already-decoded character, one nibble per common line, into consecutive addresses and steps the pointer by the number of active commons. The pointer wraps modulo 32.

Releasing chip-select copies the whole memory into a shadow display latch in a single clock. A free-running scanner steps through the common phases, with a programmable dwell, and selects one bit column of the latch onto the 32 segment outputs. Segment output Sa shows bit k of latch address a while common k is active. A short-scan mode uses three commons instead of four. In that mode, decoded writes span three addresses and the top common line stays idle. A display-enable input blanks all segments without stopping the scan.

Top module: `lcd_seg_ctrl`

## Requirements
- R1: After reset the memory, latch and pointer hold 0, the display is off, four-common mode is in force, `com_act` is 4'b0001 and `seg` is all zero.
- R2: With `cs_n` low, a `nib_wr` strobe stores `nib_data` at the pointer address and advances the pointer by 1, wrapping from 31 to 0.
- R3: In four-common mode, a `dec_wr` strobe at pointer n stores `dec_data[4j+3:4j]` at address (n+j) mod 32 for j = 0..3 and leaves the pointer at (n+4) mod 32.
- R4: In short-scan mode, a `dec_wr` strobe stores nibbles j = 0..2 at (n+j) mod 32, ignores `dec_data[15:12]` and advances the pointer by 3. A run of decoded writes from address 0 therefore leaves 30 and 31 untouched on the first pass, and the next pass continues at 30, 31 and then overwrites 0.
- R5: A `ptr_ld` strobe with `cs_n` low sets the pointer to `ptr_val`. Any write strobe in the same cycle is dropped. When `dec_wr` and `nib_wr` coincide, only the decoded write takes effect.
- R6: In the cycle where `cs_n` is low after being high in the previous cycle, the pointer is cleared to 0. A write in that same cycle lands at address 0.
- R7: While `cs_n` is high, all write and load strobes are ignored, and the memory and pointer stay unchanged.
- R8: In the cycle where `cs_n` is high after being low, the whole memory, including the write of the previous cycle, is copied into the latch. At all other times the latch holds its value.
- R9: While `com_act[k]` is set and the display is enabled, `seg[a]` equals bit k of latch address a. While disabled, `seg` is all zero. `disp_on` and `short_scan` take effect one clock after they are sampled.
- R10: `com_act` is always one-hot. Each phase lasts `div_val`+1 clocks. The order is 0,1,2,3,0 in four-common mode and 0,1,2,0 in short-scan mode, and `com_act[3]` is never set in short-scan mode. The scan runs whether or not the display is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, low opens the write port, rising edge loads the latch |
| ptr_ld | input | 1 | Pointer-load strobe |
| ptr_val | input | 5 | Pointer value for a load |
| nib_wr | input | 1 | Single-nibble write strobe |
| nib_data | input | 4 | Nibble to store |
| dec_wr | input | 1 | Decoded-character write strobe |
| dec_data | input | 16 | One nibble per common, nibble j for address n+j |
| short_scan | input | 1 | 1 selects three-common mode |
| disp_on | input | 1 | Display enable |
| div_val | input | 8 | Phase dwell minus one, in clocks |
| com_act | output | 4 | One-hot active common phase |
| seg | output | 32 | Segment outputs, bit a from latch address a |

## Verification
The chip-select falling edge clears the pointer in the same cycle that a nibble or decoded write may use it. The bench drives a write together with the falling edge and then reads the result through the latch after release, expecting the data at address 0 and the pointer one step past it. The release edge and a latch-sensitive scan step also fall together with a zero divider. Every cycle, `seg` is compared against a bench-side latch model indexed by the observed common phase, so a copy that misses the previous cycle's write or lands a cycle late shows up as a segment mismatch.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  // Modulo add used for every pointer step and decoded-write address.
  function automatic int unsigned wrap_add(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned depth);
    return (base + step) % depth;
  endfunction

  // Number of addresses one decoded write covers.
  function automatic int unsigned dec_span(input logic short_scan,
                                           input int unsigned ncom);
    return short_scan ? ncom - 1 : ncom;
  endfunction

  // Highest phase index the scanner visits.
  function automatic int unsigned last_phase(input logic short_scan,
                                             input int unsigned ncom);
    return short_scan ? ncom - 2 : ncom - 1;
  endfunction

endpackage

// File: rtl/lcd_wr_ptr.sv
module lcd_wr_ptr #(
  parameter int DEPTH = 32,
  parameter int NCOM  = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          cs_fall,
  input  logic          ptr_ld,
  input  logic [AW-1:0] ptr_val,
  input  logic          nib_wr,
  input  logic          dec_wr,
  input  logic          short_scan,
  output logic          do_nib,
  output logic          do_dec,
  output logic [AW-1:0] base
);
  import lcd_seg_pkg::*;

  logic [AW-1:0] ptr_q;
  logic          do_ld;
  int unsigned   step;

  assign base   = cs_fall ? '0 : ptr_q;
  assign do_ld  = sel & ptr_ld;
  assign do_dec = sel & dec_wr & ~ptr_ld;
  assign do_nib = sel & nib_wr & ~ptr_ld & ~dec_wr;

  always_comb begin
    step = 0;
    if (do_dec)      step = dec_span(short_scan, NCOM);
    else if (do_nib) step = 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (do_ld)  ptr_q <= ptr_val;
    else if (sel)    ptr_q <= AW'(wrap_add(32'(base), step, DEPTH));
  end

  AST_NIB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    do_nib |=> ptr_q == $past(base) + AW'(1)); // R2
  AST_DEC_STEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    do_dec && !short_scan |=> ptr_q == $past(base) + AW'(NCOM)); // R3
  AST_DEC_STEP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    do_dec && short_scan |=> ptr_q == $past(base) + AW'(NCOM - 1)); // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    do_ld |=> ptr_q == $past(ptr_val)); // R5
  AST_FALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall && !ptr_ld && !dec_wr && !nib_wr |=> ptr_q == '0); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(ptr_q)); // R7

endmodule

// File: rtl/lcd_mem_latch.sv
module lcd_mem_latch #(
  parameter int DEPTH = 32,
  parameter int DW    = 4,
  parameter int NCOM  = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               do_nib,
  input  logic               do_dec,
  input  logic               short_scan,
  input  logic [AW-1:0]      base,
  input  logic [DW-1:0]      nib_data,
  input  logic [NCOM*DW-1:0] dec_data,
  input  logic               xfer,
  output logic [DEPTH*DW-1:0] lat_flat
);
  import lcd_seg_pkg::*;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] lat_q [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_cell
    logic          we;
    logic [DW-1:0] wd;

    always_comb begin
      we = 1'b0;
      wd = '0;
      if (do_nib && base == AW'(a)) begin
        we = 1'b1;
        wd = nib_data;
      end
      for (int j = 0; j < NCOM; j++) begin
        if (do_dec && (j < int'(dec_span(short_scan, NCOM))) &&
            AW'(wrap_add(32'(base), j, DEPTH)) == AW'(a)) begin
          we = 1'b1;
          wd = dec_data[j*DW +: DW];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[a] <= '0;
        lat_q[a] <= '0;
      end else begin
        if (we)   mem_q[a] <= wd;
        if (xfer) lat_q[a] <= mem_q[a];
      end
    end

    assign lat_flat[a*DW +: DW] = lat_q[a];

    AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> lat_q[a] == $past(mem_q[a])); // R8
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(lat_q[a])); // R8
  end

endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan #(
  parameter int NCOM  = 4,
  parameter int DIV_W = 8,
  localparam int PW   = $clog2(NCOM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             short_scan,
  input  logic [DIV_W-1:0] div_val,
  output logic [NCOM-1:0]  com_act,
  output logic [PW-1:0]    phase
);
  import lcd_seg_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic [PW-1:0]    ph_q;
  logic [PW-1:0]    top;
  logic             adv;

  assign top     = PW'(last_phase(short_scan, NCOM));
  assign adv     = cnt_q >= div_val;
  assign phase   = (ph_q > top) ? '0 : ph_q;
  assign com_act = NCOM'(1) << phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (adv) begin
      cnt_q <= '0;
      ph_q  <= (phase >= top) ? '0 : phase + PW'(1);
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(com_act)); // R10
  AST_SHORT_TOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    short_scan |-> !com_act[NCOM-1]); // R10
  AST_DWELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ph_q)); // R10

endmodule

// File: rtl/lcd_seg_ctrl.sv
module lcd_seg_ctrl #(
  parameter int DEPTH = 32,
  parameter int DW    = 4,
  parameter int NCOM  = 4,
  parameter int DIV_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(NCOM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               ptr_ld,
  input  logic [AW-1:0]      ptr_val,
  input  logic               nib_wr,
  input  logic [DW-1:0]      nib_data,
  input  logic               dec_wr,
  input  logic [NCOM*DW-1:0] dec_data,
  input  logic               short_scan,
  input  logic               disp_on,
  input  logic [DIV_W-1:0]   div_val,
  output logic [NCOM-1:0]    com_act,
  output logic [DEPTH-1:0]   seg
);
  logic                cs_q, short_q, disp_q;
  logic                sel, cs_fall, cs_rise;
  logic                do_nib, do_dec;
  logic [AW-1:0]       base;
  logic [DEPTH*DW-1:0] lat_flat;
  logic [PW-1:0]       phase;

  assign sel     = ~cs_n;
  assign cs_fall = sel & cs_q;
  assign cs_rise = cs_n & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      short_q <= 1'b0;
      disp_q  <= 1'b0;
    end else begin
      cs_q    <= cs_n;
      short_q <= short_scan;
      disp_q  <= disp_on;
    end
  end

  lcd_wr_ptr #(.DEPTH(DEPTH), .NCOM(NCOM)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cs_fall(cs_fall),
    .ptr_ld(ptr_ld), .ptr_val(ptr_val), .nib_wr(nib_wr), .dec_wr(dec_wr),
    .short_scan(short_q), .do_nib(do_nib), .do_dec(do_dec), .base(base)
  );

  lcd_mem_latch #(.DEPTH(DEPTH), .DW(DW), .NCOM(NCOM)) u_mem (
    .clk(clk), .rst_n(rst_n), .do_nib(do_nib), .do_dec(do_dec),
    .short_scan(short_q), .base(base), .nib_data(nib_data),
    .dec_data(dec_data), .xfer(cs_rise), .lat_flat(lat_flat)
  );

  lcd_com_scan #(.NCOM(NCOM), .DIV_W(DIV_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .short_scan(short_q), .div_val(div_val),
    .com_act(com_act), .phase(phase)
  );

  always_comb begin
    for (int a = 0; a < DEPTH; a++)
      seg[a] = disp_q & lat_flat[a*DW + int'(phase)];
  end

  AST_NO_WRITE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |-> !do_nib && !do_dec); // R7
  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_q) |-> seg == '0); // R9

endmodule

// File: tb/lcd_seg_ctrl_tb.sv
module lcd_seg_ctrl_tb;
  logic        clk = 0, rst_n = 0, cs_n = 1, ptr_ld = 0, nib_wr = 0, dec_wr = 0;
  logic [4:0]  ptr_val = 0;
  logic [3:0]  nib_data = 0;
  logic [15:0] dec_data = 0;
  logic        short_scan = 0, disp_on = 0;
  logic [7:0]  div_val = 0;
  logic [3:0]  com_act;
  logic [31:0] seg;

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_mem [32];
  logic [3:0] m_lat [32];
  int m_ptr = 0;
  bit m_csp = 1, m_short = 0, m_disp = 0;

  always #4 clk = ~clk;

  lcd_seg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
    .nib_wr(nib_wr), .nib_data(nib_data), .dec_wr(dec_wr), .dec_data(dec_data),
    .short_scan(short_scan), .disp_on(disp_on), .div_val(div_val),
    .com_act(com_act), .seg(seg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int addr_of(input int base, input int off);
    return (base + off) % 32;
  endfunction

  function automatic logic [31:0] seg_model(input int k);
    logic [31:0] v = '0;
    for (int a = 0; a < 32; a++) v[a] = m_disp & m_lat[a][k];
    return v;
  endfunction

  // Model of one clock edge, written from the requirements.
  task automatic model_edge();
    bit sel = !cs_n;
    int b;
    if (cs_n && !m_csp) for (int a = 0; a < 32; a++) m_lat[a] = m_mem[a]; // R8
    b = (sel && m_csp) ? 0 : m_ptr;                                       // R6
    if (sel) begin
      if (ptr_ld) m_ptr = ptr_val;                                        // R5
      else if (dec_wr) begin
        int span = m_short ? 3 : 4;                                       // R3 R4
        for (int j = 0; j < span; j++) m_mem[addr_of(b, j)] = dec_data[j*4 +: 4];
        m_ptr = addr_of(b, span);
      end else if (nib_wr) begin
        m_mem[b] = nib_data;                                              // R2
        m_ptr = addr_of(b, 1);
      end else m_ptr = b;
    end
    m_csp = cs_n; m_short = short_scan; m_disp = disp_on;
  endtask

  task automatic observe(input string tag);
    int k = 0;
    chk($countones(com_act) == 1, "R10 onehot", {28'd0, com_act}, 32'd1);
    for (int i = 0; i < 4; i++) if (com_act[i]) k = i;
    if (m_short) chk(!com_act[3], "R10 short top idle", {28'd0, com_act}, 32'd0);
    chk(seg == seg_model(k), tag, seg, seg_model(k));
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    observe(tag);
    ptr_ld = 0; nib_wr = 0; dec_wr = 0;
  endtask

  task automatic release_and_scan(input string tag);
    cs_n = 1; step(tag);
    for (int i = 0; i < 4; i++) step(tag);
  endtask

  task automatic measure_dwell(input int div, input bit shrt);
    logic [3:0] prev, nxt;
    int len;
    div_val = div[7:0]; short_scan = shrt;
    for (int i = 0; i < 12; i++) step("R10 settle");
    prev = com_act;
    while (com_act == prev) step("R10 sync");
    for (int rep = 0; rep < 4; rep++) begin
      prev = com_act; len = 0;
      while (com_act == prev && len < 300) begin step("R10 dwell"); len++; end
      chk(len == div + 1, "R10 dwell length", len, div + 1);
      nxt = (prev == 4'b1000 || (shrt && prev == 4'b0100)) ? 4'b0001 : prev << 1;
      chk(com_act == nxt, "R10 order", {28'd0, com_act}, {28'd0, nxt});
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);
    for (int a = 0; a < 32; a++) begin m_mem[a] = 0; m_lat[a] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(com_act == 4'b0001, "R1 reset com", {28'd0, com_act}, 32'd1);
    chk(seg == 0, "R1 reset seg", seg, 0);
    disp_on = 1;
    for (int i = 0; i < 4; i++) step("R1 latch clear");

    // Four-common decoded write across the wrap, then a nibble.
    cs_n = 0; step("R6 open");
    ptr_ld = 1; ptr_val = 30; step("R5 load");
    dec_wr = 1; dec_data = 16'hDCBA; step("R3 wrap write");
    nib_wr = 1; nib_data = 4'h5; step("R2 nibble");
    nib_wr = 1; nib_data = 4'h9; step("R2 nibble");
    release_and_scan("R3 latch view");
    chk(m_lat[30] == 4'hA && m_lat[1] == 4'hD && m_lat[2] == 4'h5, "R3 model spot",
        {m_lat[30], m_lat[1], m_lat[2]}, 12'hAD5);

    // Load and decoded write in one cycle: load wins. Dec beats nib.
    cs_n = 0; step("R6 open");
    ptr_ld = 1; ptr_val = 7; dec_wr = 1; dec_data = 16'hFFFF; step("R5 load wins");
    dec_wr = 1; nib_wr = 1; dec_data = 16'h1234; nib_data = 4'hE; step("R5 dec beats nib");
    release_and_scan("R5 latch view");

    // Fall edge together with a write: lands at address 0.
    ptr_ld = 0; step("R8 idle");
    cs_n = 0; nib_wr = 1; nib_data = 4'h6; step("R6 fall write");
    nib_wr = 1; nib_data = 4'h3; step("R6 follow write");
    release_and_scan("R6 latch view");
    chk(m_lat[0] == 4'h6 && m_lat[1] == 4'h3, "R6 addr0", {m_lat[0], m_lat[1]}, 8'h63);

    // Strobes while deselected are ignored; second release shows same latch.
    nib_wr = 1; nib_data = 4'hF; step("R7 ignored nib");
    dec_wr = 1; dec_data = 16'hFFFF; step("R7 ignored dec");
    ptr_ld = 1; ptr_val = 3; step("R7 ignored load");
    cs_n = 0; step("R7 open");
    nib_wr = 1; nib_data = 4'hC; step("R7 ptr cleared not 3");
    release_and_scan("R7 latch view");

    // Display off: segments dark, scan keeps running.
    disp_on = 0;
    for (int i = 0; i < 6; i++) step("R9 dark");
    disp_on = 1;
    for (int i = 0; i < 4; i++) step("R9 lit");

    // Short-scan decoded writes from 0: eleven writes reach 30, 31, 0.
    short_scan = 1; step("R4 mode");
    cs_n = 0; step("R4 open");
    for (int w = 0; w < 11; w++) begin
      dec_wr = 1; dec_data = {4'hF, 4'(w*3+2), 4'(w*3+1), 4'(w*3)}; step("R4 write");
    end
    release_and_scan("R4 latch view");
    chk(m_lat[30] == 4'(30) && m_lat[31] == 4'(31) && m_lat[0] == 4'(32),
        "R4 wrap", {m_lat[30], m_lat[31], m_lat[0]}, {4'(30), 4'(31), 4'(32)});
    for (int i = 0; i < 6; i++) step("R4 short scan");

    measure_dwell(3, 0);
    measure_dwell(2, 1);
    measure_dwell(0, 0);

    // Random mix.
    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 12;
      case (op)
        0, 1: cs_n = ~cs_n;
        2: begin ptr_ld = 1; ptr_val = 5'($urandom); end
        3, 4, 5: begin nib_wr = 1; nib_data = 4'($urandom); end
        6, 7: begin dec_wr = 1; dec_data = 16'($urandom); nib_wr = $urandom % 2; end
        8: disp_on = ~disp_on;
        9: short_scan = ~short_scan;
        10: div_val = 8'($urandom % 3);
        default: ;
      endcase
      step("R9 random");
    end
    cs_n = 1; disp_on = 1;
    for (int i = 0; i < 6; i++) step("R8 random final");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule